// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block produces the command stream an SDR SDRAM needs after power-up and during normal life. A host writes a few configuration registers through a one-cycle write strobe, select and data bus. A start request makes the block issue PRECHARGE ALL, wait, then issue a programmed number of AUTO REFRESH commands, each with its own wait. A write of the mode word issues LOAD MODE REGISTER with the word on the address lines. Once configured, the block can raise AUTO REFRESH at a programmed interval for as long as refresh is switched on.

Three busy flags show which operation is running. While any of them is set, every configuration write except the refresh on/off switch is dropped. The 100 µs clock-stabilisation delay before the first start request is the host's job.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command pins carry NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1), the address is zero and all three busy flags are low.
- R2: Writing select 1 with data bit 0 set, while no busy flag is set, raises `init_busy` from that edge and issues PRECHARGE ALL (0,0,1,0) one cycle later with address bit 10 high and all other address bits low.
- R3: The first AUTO REFRESH (0,0,0,1) of the start sequence follows PRECHARGE ALL by the precharge field of select 0 (bits [7:0]) plus 3 cycles.
- R4: The start sequence issues as many AUTO REFRESH commands as select 0 bits [19:16] hold, each one separated from the previous one by the refresh field (bits [15:8]) plus 3 cycles. `init_busy` falls that same wait after the last of them, or after the precharge wait when the count is zero.
- R5: Writing select 2 while idle issues LOAD MODE REGISTER (0,0,0,0) one cycle later, with data bits [9:0] on address [9:0], zero on the remaining address bits and on the bank lines. The word holds burst length in [2:0], burst type in 3, CAS latency in [6:4], operating mode in [8:7] and write-burst mode in 9.
- R6: `mode_busy` is high from the mode write edge until TMRD cycles after LOAD MODE REGISTER.
- R7: Writes to selects 0, 1, 2 and 3 made while any busy flag is set are dropped without effect. At most one busy flag is set at a time.
- R8: With refresh enabled (select 4 bit 0), AUTO REFRESH is raised every interval field (select 3 bits [11:0]) plus 1 cycles counted from the enable edge, issued one cycle after it falls due. `ref_busy` stays high for the refresh-cycle field (select 3 bits [23:16]) plus 1 cycles from that command.
- R9: Select 4 is writable at any time. While refresh is disabled no periodic AUTO REFRESH is issued.
- R10: A periodic refresh that falls due during another operation is held and issued in the cycle after that operation's wait ends. Several refreshes that fall due during one operation merge into one.
- R11: Every command is followed by at least one NOP, and no encodings other than the four above appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select (0 start config, 1 start, 2 mode, 3 refresh config, 4 refresh enable) |
| cfg_wdata | input | DATA_W | Write data |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address lines (mode word, precharge-all bit) |
| ba | output | BA_W | Bank lines, always zero |
| init_busy | output | 1 | Start sequence running |
| mode_busy | output | 1 | Mode load and its delay running |
| ref_busy | output | 1 | Periodic refresh wait running |

## Verification
A write is taken at the clock edge after it is driven. Its busy flag reads high from that edge, and its first command appears one edge later. Each later command and each falling busy flag lands exactly the programmed count of edges after the command before it, so every expected command is queued with its exact edge number and compared against a counter of edges. Status is sampled at the falling edge of the precise cycle the requirements predict, both on the last busy cycle and on the first idle one. Dropped writes are caught either as unexpected commands or by repeating a sequence and seeing the old timing.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Pin order {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_NOP  = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        SEL_INIT_CFG = 3'd0,
        SEL_INIT_GO  = 3'd1,
        SEL_MODE     = 3'd2,
        SEL_REF_CFG  = 3'd3,
        SEL_REF_EN   = 3'd4
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_PRE,
        ST_INIT_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_REF_WAIT
    } seq_state_e;

    // Field order is the device's decode order, MSB first
    typedef struct packed {
        logic       wr_burst;
        logic [1:0] op_mode;
        logic [2:0] cas_lat;
        logic       burst_type;
        logic [2:0] burst_len;
    } mode_word_t;

    localparam int MODE_W      = $bits(mode_word_t);
    localparam int AP_BIT      = 10;
    localparam int TRFC_LSB    = 16;
    localparam int INIT_OFFSET = 3;

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sdram_seq_refresh.sv
module sdram_seq_refresh #(
    parameter int IVL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [IVL_W-1:0] ivl,
    input  logic             take,
    output logic             pend
);
    logic [IVL_W-1:0] cnt_q;
    logic             pend_q;
    logic             due;

    assign due = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= ivl;
            pend_q <= 1'b0;
        end else if (!en) begin
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= due ? ivl : cnt_q - 1'b1;
            pend_q <= (pend_q & ~take) | due;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/sdram_seq_cfg.sv
module sdram_seq_cfg
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 4,
    parameter int IVL_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              idle,
    output logic [WAIT_W-1:0] pre_m3,
    output logic [WAIT_W-1:0] rfc_m3,
    output logic [CNT_W-1:0]  ref_cnt,
    output mode_word_t        mode,
    output logic [IVL_W-1:0]  ivl_m1,
    output logic [WAIT_W-1:0] trfc_m1,
    output logic              ref_en,
    output logic              init_go,
    output logic              mode_go,
    output logic              en_load
);
    localparam int RFC_LSB = WAIT_W;
    localparam int CNT_LSB = 2 * WAIT_W;

    logic wr_ok;
    logic unused_wdata;

    assign unused_wdata = &{1'b0, wdata};
    assign wr_ok   = we && idle;
    assign init_go = wr_ok && (sel == SEL_INIT_GO) && wdata[0];
    assign mode_go = wr_ok && (sel == SEL_MODE);
    assign en_load = we && (sel == SEL_REF_EN) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_m3  <= '0;
            rfc_m3  <= '0;
            ref_cnt <= CNT_W'(2);
            mode    <= '0;
            ivl_m1  <= '0;
            trfc_m1 <= '0;
            ref_en  <= 1'b0;
        end else begin
            if (wr_ok && sel == SEL_INIT_CFG) begin
                pre_m3  <= wdata[WAIT_W-1:0];
                rfc_m3  <= wdata[RFC_LSB +: WAIT_W];
                ref_cnt <= wdata[CNT_LSB +: CNT_W];
            end
            if (mode_go) begin
                mode <= mode_word_t'(wdata[MODE_W-1:0]);
            end
            if (wr_ok && sel == SEL_REF_CFG) begin
                ivl_m1  <= wdata[IVL_W-1:0];
                trfc_m1 <= wdata[TRFC_LSB +: WAIT_W];
            end
            if (we && sel == SEL_REF_EN) begin
                ref_en <= wdata[0];
            end
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int WAIT_W = 8,
    parameter int CNT_W  = 4,
    parameter int IVL_W  = 12,
    parameter int TMRD   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_busy,
    output logic              mode_busy,
    output logic              ref_busy
);
    localparam int TMR_W = WAIT_W + 1;

    seq_state_e        state_q, state_d;
    cmd_e              cmd_q, cmd_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [CNT_W-1:0]  refs_q, refs_d;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              ref_take, ref_pend;
    logic              idle;

    logic [WAIT_W-1:0] pre_m3, rfc_m3, trfc_m1;
    logic [CNT_W-1:0]  ref_cnt;
    logic [IVL_W-1:0]  ivl_m1;
    mode_word_t        mode;
    logic              ref_en, init_go, mode_go, en_load;

    assign idle = (state_q == ST_IDLE);

    sdram_seq_cfg #(
        .DATA_W(DATA_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W), .IVL_W(IVL_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .idle(idle), .pre_m3(pre_m3), .rfc_m3(rfc_m3), .ref_cnt(ref_cnt),
        .mode(mode), .ivl_m1(ivl_m1), .trfc_m1(trfc_m1), .ref_en(ref_en),
        .init_go(init_go), .mode_go(mode_go), .en_load(en_load)
    );

    sdram_seq_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    sdram_seq_refresh #(.IVL_W(IVL_W)) u_ref (
        .clk(clk), .rst(rst), .en(ref_en), .load(en_load), .ivl(ivl_m1),
        .take(ref_take), .pend(ref_pend)
    );

    // Waits load "cycles - 1"; init fields are stored as cycles - 3
    always_comb begin
        state_d  = state_q;
        refs_d   = refs_q;
        cmd_d    = CMD_NOP;
        addr_d   = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (init_go) begin
                    state_d = ST_INIT_PRE;
                    refs_d  = ref_cnt;
                end else if (mode_go) begin
                    state_d = ST_MRS;
                end else if (ref_pend && ref_en) begin
                    cmd_d    = CMD_AREF;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(trfc_m1);
                    ref_take = 1'b1;
                    state_d  = ST_REF_WAIT;
                end
            end
            ST_INIT_PRE: begin
                cmd_d          = CMD_PALL;
                addr_d[AP_BIT] = 1'b1;
                tmr_load       = 1'b1;
                tmr_val        = TMR_W'(pre_m3) + TMR_W'(INIT_OFFSET - 1);
                state_d        = ST_INIT_WAIT;
            end
            ST_INIT_WAIT: begin
                if (tmr_done) begin
                    if (refs_q != '0) begin
                        cmd_d    = CMD_AREF;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(rfc_m3) + TMR_W'(INIT_OFFSET - 1);
                        refs_d   = refs_q - 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_MRS: begin
                cmd_d               = CMD_LMR;
                addr_d[MODE_W-1:0]  = mode;
                tmr_load            = 1'b1;
                tmr_val             = TMR_W'(TMRD - 1);
                state_d             = ST_MRS_WAIT;
            end
            ST_MRS_WAIT, ST_REF_WAIT: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            refs_q  <= '0;
            cmd_q   <= CMD_NOP;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            refs_q  <= refs_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign addr      = addr_q;
    assign ba        = '0;
    assign init_busy = (state_q == ST_INIT_PRE) || (state_q == ST_INIT_WAIT);
    assign mode_busy = (state_q == ST_MRS) || (state_q == ST_MRS_WAIT);
    assign ref_busy  = (state_q == ST_REF_WAIT);
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              init_busy,
    input logic              mode_busy,
    input logic              ref_busy
);
    logic [3:0] pins;
    logic [2:0] busy;
    assign pins = {cs_n, ras_n, cas_n, we_n};
    assign busy = {init_busy, mode_busy, ref_busy};

    // R11
    legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        pins inside {CMD_NOP, CMD_PALL, CMD_AREF, CMD_LMR});

    // R11
    nop_gap_chk: assert property (@(posedge clk) disable iff (rst)
        pins != CMD_NOP |=> pins == CMD_NOP);

    // R2
    pall_ap_chk: assert property (@(posedge clk) disable iff (rst)
        pins == CMD_PALL |-> addr[AP_BIT]);

    // R2
    init_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_busy) |=> pins == CMD_PALL);

    // R5
    lmr_owner_chk: assert property (@(posedge clk) disable iff (rst)
        pins == CMD_LMR |-> mode_busy);

    // R8
    aref_owner_chk: assert property (@(posedge clk) disable iff (rst)
        pins == CMD_AREF |-> (init_busy || ref_busy));

    // R7
    one_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy));

    // R7
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_busy) |-> $past(busy) == 3'b000);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .init_busy(init_busy), .mode_busy(mode_busy),
    .ref_busy(ref_busy)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
    localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, AREF = 4'b0001, LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [12:0] addr;
    logic [1:0]  ba;
    logic        init_busy, mode_busy, ref_busy;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0]  cmd;
        int          at;
        logic [12:0] adr;
        string       req;
    } exp_t;
    exp_t sb[$];

    sdram_init_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr), .ba(ba), .init_busy(init_busy),
        .mode_busy(mode_busy), .ref_busy(ref_busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic wr_at(input int t, input logic [2:0] sel, input logic [31:0] d);
        while (cyc < t - 1) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_cmd(input logic [3:0] c, input int t, input logic [12:0] a, input string req);
        exp_t e;
        e.cmd = c; e.at = t; e.adr = a; e.req = req;
        sb.push_back(e);
    endtask

    task automatic chk_st(input int t, input logic [2:0] exp, input string req);
        while (cyc < t) @(negedge clk);
        checks++;
        if ({init_busy, mode_busy, ref_busy} !== exp || cyc != t) begin
            errors++;
            $display("FAIL %s: status at cycle %0d act=%b exp=%b (at %0d)",
                     req, t, {init_busy, mode_busy, ref_busy}, exp, cyc);
        end
    endtask

    // Scoreboard monitor: every non-NOP command must match the queue head
    always @(negedge clk) begin
        if (!rst && {cs_n, ras_n, cas_n, we_n} != NOP) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R7/R9: unexpected cmd %b at cycle %0d addr=%h exp=none",
                         {cs_n, ras_n, cas_n, we_n}, cyc, addr);
            end else begin
                e = sb.pop_front();
                if (e.cmd !== {cs_n, ras_n, cas_n, we_n} || e.at != cyc ||
                    e.adr !== addr || ba !== 2'b00) begin
                    errors++;
                    $display("FAIL %s: act cmd=%b cyc=%0d addr=%h ba=%b exp cmd=%b cyc=%0d addr=%h ba=00",
                             e.req, {cs_n, ras_n, cas_n, we_n}, cyc, addr, ba,
                             e.cmd, e.at, e.adr);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_st(8, 3'b000, "R1");
        checks++;
        if ({cs_n, ras_n, cas_n, we_n} !== NOP || addr !== '0) begin
            errors++;
            $display("FAIL R1: act cmd=%b addr=%h exp cmd=%b addr=0",
                     {cs_n, ras_n, cas_n, we_n}, addr, NOP);
        end

        // R5/R6 mode word: wb=1 op=0 cl=2 bt=0 bl=3 -> 0x223
        wr_at(10, 3'd2, 32'h0000_0223);
        expect_cmd(LMR, 11, 13'h0223, "R5");
        chk_st(10, 3'b010, "R6");
        chk_st(12, 3'b010, "R6");
        chk_st(13, 3'b000, "R6");

        // R2/R3/R4 start: pre field 2 (5 cyc), refresh field 1 (4 cyc), 3 refreshes
        wr_at(15, 3'd0, 32'h0003_0102);
        wr_at(20, 3'd1, 32'h1);
        expect_cmd(PALL, 21, 13'h0400, "R2");
        expect_cmd(AREF, 26, 13'h0000, "R3");
        expect_cmd(AREF, 30, 13'h0000, "R4");
        expect_cmd(AREF, 34, 13'h0000, "R4");
        chk_st(20, 3'b100, "R2");
        wr_at(23, 3'd2, 32'h0000_0155);   // R7: dropped, no LMR may follow
        wr_at(25, 3'd0, 32'h0000_0000);   // R7: dropped, next run keeps old timing
        chk_st(37, 3'b100, "R4");
        chk_st(38, 3'b000, "R4");

        // R7 repeat start shows the configuration was not overwritten
        wr_at(40, 3'd1, 32'h1);
        expect_cmd(PALL, 41, 13'h0400, "R7");
        expect_cmd(AREF, 46, 13'h0000, "R7");
        expect_cmd(AREF, 50, 13'h0000, "R7");
        expect_cmd(AREF, 54, 13'h0000, "R7");
        chk_st(57, 3'b100, "R7");
        chk_st(58, 3'b000, "R7");

        // R4 zero refresh count, shortest precharge wait (3 cycles)
        wr_at(60, 3'd0, 32'h0000_0000);
        wr_at(62, 3'd1, 32'h1);
        expect_cmd(PALL, 63, 13'h0400, "R4");
        chk_st(65, 3'b100, "R4");
        chk_st(66, 3'b000, "R4");

        // R8 periodic refresh: interval field 19 (20 cyc), refresh-cycle field 2 (3 cyc)
        wr_at(70, 3'd3, 32'h0002_0013);
        wr_at(72, 3'd4, 32'h1);
        expect_cmd(AREF, 93, 13'h0000, "R8");
        expect_cmd(AREF, 113, 13'h0000, "R8");
        expect_cmd(AREF, 133, 13'h0000, "R8");
        chk_st(93, 3'b001, "R8");
        wr_at(94, 3'd3, 32'h0000_0004);   // R7: dropped during ref_busy
        chk_st(95, 3'b001, "R8");
        chk_st(96, 3'b000, "R8");

        // R9 disable: nothing more until the next scenario
        wr_at(137, 3'd4, 32'h0);

        // R10 refresh falls due during the start sequence
        wr_at(200, 3'd0, 32'h0003_0102);
        wr_at(202, 3'd3, 32'h0000_0009);
        wr_at(204, 3'd4, 32'h1);
        wr_at(206, 3'd1, 32'h1);          // R9: enable was accepted regardless
        expect_cmd(PALL, 207, 13'h0400, "R10");
        expect_cmd(AREF, 212, 13'h0000, "R10");
        expect_cmd(AREF, 216, 13'h0000, "R10");
        expect_cmd(AREF, 220, 13'h0000, "R10");
        expect_cmd(AREF, 225, 13'h0000, "R10");
        expect_cmd(AREF, 235, 13'h0000, "R10");
        expect_cmd(AREF, 245, 13'h0000, "R10");
        chk_st(223, 3'b100, "R10");
        chk_st(224, 3'b000, "R10");
        chk_st(225, 3'b001, "R10");
        chk_st(226, 3'b000, "R10");
        wr_at(249, 3'd4, 32'h0);

        while (cyc < 320) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R11: commands missing act=%0d exp=0", sb.size());
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule